// File: doc/BRIEF.md
# AXI Burst Type Normalizer

This block sits on the request side of one AXI4 address channel (read or write) and rewrites each incoming request into a form that downstream logic can take without special cases. INCR requests go through unchanged. A WRAP request is reissued as INCR traffic that begins at the aligned wrap boundary. If the start address already sits on that boundary, the block emits one INCR burst of the same length. Otherwise it emits a string of single-beat INCR requests, one per beat, that walk upward from the boundary.

FIXED requests, reserved burst codes and WRAP requests with an illegal length are never forwarded. For each of them the block raises a one-cycle error pulse that carries the request's ID and length, so that a responder can return DECERR for every beat. Every forwarded piece has its lock bit cleared and its region field forced to zero, while QoS is copied through untouched. Each piece is tagged with the total number of pieces in its request and with a last-piece flag, so that a response path can merge split write responses into one, or rebuild RLAST.

Only one request is handled at a time. The input is not ready again until the last piece of the current request has been accepted downstream.

Top module: `axi_burst_normalizer`

## Requirements
- R1: A request with burst code 2'b01 (INCR) produces exactly one output piece with the same ID, address, len and size, burst code 2'b01, piece count 1 and the last-piece flag set.
- R2: A WRAP request (burst code 2'b10) whose address equals its wrap boundary produces one INCR piece with the same address, len and size, piece count 1 and the last-piece flag set. The wrap boundary is the address rounded down to a multiple of (len+1)·2^size.
- R3: A WRAP request whose address differs from its wrap boundary produces len+1 single-beat INCR pieces (len 0, same size). Piece i carries address boundary + i·2^size and piece count len+1. Only the final piece has the last-piece flag set.
- R4: A request with burst code 2'b00 (FIXED) or 2'b11 (reserved), or a WRAP request whose len is not 1, 3, 7 or 15, produces no output piece. Instead, err_valid is high for exactly the one cycle after acceptance, with err_id and err_len equal to the request's ID and len.
- R5: Every output piece has out_lock low, whatever the input lock bit was.
- R6: Every output piece carries the QoS value of its request unchanged.
- R7: Every output piece has out_region equal to zero, whatever the input region was.
- R8: in_ready is low from the cycle after a forwarded request is accepted until the cycle after its last piece is accepted. It is high whenever no piece is pending and reset is inactive.
- R9: While out_valid is high and out_ready is low, all output fields hold their values.
- R10: While reset is active and in the first cycle after it, out_valid and err_valid are low. in_ready is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_id | input | ID_W | Request ID |
| in_addr | input | ADDR_W | Request start address |
| in_len | input | 8 | Beats minus one |
| in_size | input | 3 | Log2 of bytes per beat |
| in_burst | input | 2 | Burst type code |
| in_lock | input | 1 | Lock bit, discarded |
| in_qos | input | QOS_W | Quality-of-service value |
| in_region | input | 4 | Region field, discarded |
| out_valid | output | 1 | Output piece valid |
| out_ready | input | 1 | Downstream accepts the piece |
| out_id | output | ID_W | Piece ID |
| out_addr | output | ADDR_W | Piece address |
| out_len | output | 8 | Piece beats minus one |
| out_size | output | 3 | Piece beat size |
| out_burst | output | 2 | Always INCR (2'b01) |
| out_lock | output | 1 | Always low |
| out_qos | output | QOS_W | Copied QoS |
| out_region | output | 4 | Always zero |
| out_pieces | output | 5 | Number of pieces in this request |
| out_last_piece | output | 1 | High on the final piece of a request |
| err_valid | output | 1 | One-cycle pulse for a rejected request |
| err_id | output | ID_W | ID of the rejected request |
| err_len | output | 8 | Len of the rejected request |

## Verification
The assertions assume that the upstream master keeps a WRAP start address aligned to its beat size, as the protocol demands. They also assume that reset is held for at least one clock edge before any request arrives. The address-step property depends on the first of these, since a misaligned start would make the boundary walk differ from the master's view. The bench builds every random WRAP address by masking off the low size bits, and it drives requests only after reset has been released. Random back-pressure on out_ready exercises the hold and busy rules over many stall lengths.

// File: rtl/anrm_pkg.sv
package anrm_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  typedef enum logic [1:0] {
    RK_PASS,
    RK_WHOLE,
    RK_SPLIT,
    RK_ERR
  } req_kind_e;
endpackage

// File: rtl/anrm_classify.sv
module anrm_classify
  import anrm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int PCW    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output req_kind_e         kind,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  start_len,
  output logic [PCW-1:0]    pieces
);
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] boundary;
  logic              len_legal;

  always_comb begin
    span      = (ADDR_W'(len) + ADDR_W'(1)) << size;
    low_mask  = span - ADDR_W'(1);
    boundary  = addr & ~low_mask;
    len_legal = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                (len == LEN_W'(7)) || (len == LEN_W'(15));
  end

  always_comb begin
    kind = RK_ERR;
    case (burst_e'(burst))
      BT_INCR: kind = RK_PASS;
      BT_WRAP: begin
        if (!len_legal)            kind = RK_ERR;
        else if (boundary == addr) kind = RK_WHOLE;
        else                       kind = RK_SPLIT;
      end
      default: kind = RK_ERR;
    endcase
  end

  always_comb begin
    start_addr = (kind == RK_PASS) ? addr : boundary;
    start_len  = (kind == RK_SPLIT) ? '0 : len;
    pieces     = (kind == RK_SPLIT) ? PCW'(len[3:0]) + PCW'(1) : PCW'(1);
  end
endmodule

// File: rtl/anrm_piece_gen.sv
module anrm_piece_gen #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int QOS_W  = 4,
  parameter int PCW    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ID_W-1:0]   ld_id,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [2:0]        ld_size,
  input  logic [QOS_W-1:0]  ld_qos,
  input  logic [PCW-1:0]    ld_pieces,
  input  logic              pop,
  output logic              busy,
  output logic [ID_W-1:0]   id_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [2:0]        size_q,
  output logic [QOS_W-1:0]  qos_q,
  output logic [PCW-1:0]    pieces_q,
  output logic              last_q
);
  logic [PCW-1:0]    idx_q;
  logic [PCW-1:0]    idx_nxt;
  logic [ADDR_W-1:0] step;

  assign idx_nxt = idx_q + PCW'(1);
  assign step    = ADDR_W'(1) << size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      id_q     <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      size_q   <= '0;
      qos_q    <= '0;
      pieces_q <= '0;
      idx_q    <= '0;
      last_q   <= 1'b0;
    end else if (load) begin
      busy     <= 1'b1;
      id_q     <= ld_id;
      addr_q   <= ld_addr;
      len_q    <= ld_len;
      size_q   <= ld_size;
      qos_q    <= ld_qos;
      pieces_q <= ld_pieces;
      idx_q    <= PCW'(1);
      last_q   <= (ld_pieces == PCW'(1));
    end else if (busy && pop) begin
      if (last_q) begin
        busy <= 1'b0;
      end else begin
        addr_q <= addr_q + step;
        idx_q  <= idx_nxt;
        last_q <= (idx_nxt == pieces_q);
      end
    end
  end
endmodule

// File: rtl/anrm_err_pulse.sv
module anrm_err_pulse #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [ID_W-1:0]  f_id,
  input  logic [LEN_W-1:0] f_len,
  output logic             e_valid,
  output logic [ID_W-1:0]  e_id,
  output logic [LEN_W-1:0] e_len
);
  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= 1'b0;
      e_id    <= '0;
      e_len   <= '0;
    end else begin
      e_valid <= fire;
      if (fire) begin
        e_id  <= f_id;
        e_len <= f_len;
      end
    end
  end
endmodule

// File: rtl/axi_burst_normalizer.sv
module axi_burst_normalizer
  import anrm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int QOS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_len,
  input  logic [2:0]        in_size,
  input  logic [1:0]        in_burst,
  input  logic              in_lock,
  input  logic [QOS_W-1:0]  in_qos,
  input  logic [3:0]        in_region,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [ADDR_W-1:0] out_addr,
  output logic [7:0]        out_len,
  output logic [2:0]        out_size,
  output logic [1:0]        out_burst,
  output logic              out_lock,
  output logic [QOS_W-1:0]  out_qos,
  output logic [3:0]        out_region,
  output logic [4:0]        out_pieces,
  output logic              out_last_piece,
  output logic              err_valid,
  output logic [ID_W-1:0]   err_id,
  output logic [7:0]        err_len
);
  localparam int LEN_W   = 8;
  localparam int MAX_PCS = 16;
  localparam int PCW     = $clog2(MAX_PCS + 1);
  localparam logic       LOCK_KEEP   = 1'b0;
  localparam logic [3:0] REGION_KEEP = 4'h0;

  req_kind_e         kind;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  start_len;
  logic [PCW-1:0]    pieces;
  logic              busy;
  logic              take;

  assign in_ready = !busy && !rst;
  assign take     = in_valid && in_ready;

  anrm_classify #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PCW(PCW)) u_cls (
    .addr       (in_addr),
    .len        (in_len),
    .size       (in_size),
    .burst      (in_burst),
    .kind       (kind),
    .start_addr (start_addr),
    .start_len  (start_len),
    .pieces     (pieces)
  );

  anrm_piece_gen #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W), .QOS_W(QOS_W), .PCW(PCW)
  ) u_gen (
    .clk       (clk),
    .rst       (rst),
    .load      (take && (kind != RK_ERR)),
    .ld_id     (in_id),
    .ld_addr   (start_addr),
    .ld_len    (start_len),
    .ld_size   (in_size),
    .ld_qos    (in_qos),
    .ld_pieces (pieces),
    .pop       (out_ready),
    .busy      (busy),
    .id_q      (out_id),
    .addr_q    (out_addr),
    .len_q     (out_len),
    .size_q    (out_size),
    .qos_q     (out_qos),
    .pieces_q  (out_pieces),
    .last_q    (out_last_piece)
  );

  anrm_err_pulse #(.ID_W(ID_W), .LEN_W(LEN_W)) u_err (
    .clk     (clk),
    .rst     (rst),
    .fire    (take && (kind == RK_ERR)),
    .f_id    (in_id),
    .f_len   (in_len),
    .e_valid (err_valid),
    .e_id    (err_id),
    .e_len   (err_len)
  );

  assign out_valid  = busy;
  assign out_burst  = BT_INCR;
  assign out_lock   = in_lock & LOCK_KEEP;
  assign out_region = in_region & REGION_KEEP;
endmodule

// File: rtl/anrm_checker.sv
module anrm_checker #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ID_W-1:0]   out_id,
  input logic [ADDR_W-1:0] out_addr,
  input logic [7:0]        out_len,
  input logic [2:0]        out_size,
  input logic [1:0]        out_burst,
  input logic              out_lock,
  input logic [3:0]        out_region,
  input logic [4:0]        out_pieces,
  input logic              out_last_piece,
  input logic              err_valid
);
  AST_BURST_INCR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_burst == 2'b01); // R1

  AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pieces > 5'd1) |-> out_len == 8'd0); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last_piece) |=>
      (out_valid && out_addr == $past(out_addr) + (ADDR_W'(1) << $past(out_size)))); // R3

  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> !out_valid); // R4

  AST_LOCK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_lock); // R5

  AST_REGION_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_region == 4'h0); // R7

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_id) && $stable(out_len) &&
       $stable(out_last_piece) && $stable(out_pieces))); // R9
endmodule

bind axi_burst_normalizer anrm_checker #(.ADDR_W(ADDR_W), .ID_W(ID_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_id         (out_id),
  .out_addr       (out_addr),
  .out_len        (out_len),
  .out_size       (out_size),
  .out_burst      (out_burst),
  .out_lock       (out_lock),
  .out_region     (out_region),
  .out_pieces     (out_pieces),
  .out_last_piece (out_last_piece),
  .err_valid      (err_valid)
);

// File: tb/axi_burst_normalizer_tb_top.sv
module axi_burst_normalizer_tb_top;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 4;
  localparam int QOS_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ID_W-1:0]   in_id = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [7:0]        in_len = '0;
  logic [2:0]        in_size = '0;
  logic [1:0]        in_burst = '0;
  logic              in_lock = 1'b0;
  logic [QOS_W-1:0]  in_qos = '0;
  logic [3:0]        in_region = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ID_W-1:0]   out_id;
  logic [ADDR_W-1:0] out_addr;
  logic [7:0]        out_len;
  logic [2:0]        out_size;
  logic [1:0]        out_burst;
  logic              out_lock;
  logic [QOS_W-1:0]  out_qos;
  logic [3:0]        out_region;
  logic [4:0]        out_pieces;
  logic              out_last_piece;
  logic              err_valid;
  logic [ID_W-1:0]   err_id;
  logic [7:0]        err_len;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  axi_burst_normalizer #(.ADDR_W(ADDR_W), .ID_W(ID_W), .QOS_W(QOS_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Expected shape of a request, derived from the requirements.
  // kind: 0 error, 1 single piece, 2 split into single beats.
  function automatic int exp_kind(input logic [1:0] b, input logic [7:0] l,
                                  input logic [31:0] a, input logic [2:0] s);
    longint span;
    if (b == 2'b01) return 1;
    if (b != 2'b10) return 0;
    if (!(l == 1 || l == 3 || l == 7 || l == 15)) return 0;
    span = (longint'(l) + 1) * (longint'(1) << s);
    return ((longint'(a) % span) == 0) ? 1 : 2;
  endfunction

  function automatic logic [31:0] exp_bound(input logic [7:0] l,
                                            input logic [31:0] a, input logic [2:0] s);
    longint span;
    span = (longint'(l) + 1) * (longint'(1) << s);
    return 32'(longint'(a) - (longint'(a) % span));
  endfunction

  task automatic run_req(input logic [3:0] id, input logic [31:0] a, input logic [7:0] l,
                         input logic [2:0] s, input logic [1:0] b, input logic lk,
                         input logic [3:0] q, input logic [3:0] rg);
    int k;
    int n;
    int got;
    logic [31:0] base;
    k = exp_kind(b, l, a, s);
    n = (k == 2) ? int'(l) + 1 : 1;
    base = (k == 2) ? exp_bound(l, a, s) : a;
    in_id = id; in_addr = a; in_len = l; in_size = s; in_burst = b;
    in_lock = lk; in_qos = q; in_region = rg; in_valid = 1'b1;
    chk(in_ready, "R8", "in_ready idle", longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_region = 4'hF;
    in_lock = 1'b1;
    if (k == 0) begin
      chk(err_valid, "R4", "err_valid pulse", longint'(err_valid), 1);
      chk(err_id == id, "R4", "err_id", longint'(err_id), longint'(id));
      chk(err_len == l, "R4", "err_len", longint'(err_len), longint'(l));
      chk(!out_valid, "R4", "no piece", longint'(out_valid), 0);
      @(negedge clk);
      chk(!err_valid, "R4", "pulse width", longint'(err_valid), 0);
      chk(!out_valid, "R4", "no piece later", longint'(out_valid), 0);
      return;
    end
    got = 0;
    while (got < n) begin
      chk(out_valid, "R8", "piece pending", longint'(out_valid), 1);
      chk(!in_ready, "R8", "in_ready busy", longint'(in_ready), 0);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        chk(out_id == id, "R1", "id", longint'(out_id), longint'(id));
        chk(out_addr == base + 32'(got << s), (k == 2) ? "R3" : "R2", "addr",
            longint'(out_addr), longint'(base + 32'(got << s)));
        chk(out_len == ((k == 2) ? 8'd0 : l), (k == 2) ? "R3" : "R1", "len",
            longint'(out_len), longint'((k == 2) ? 8'd0 : l));
        chk(out_size == s, "R1", "size", longint'(out_size), longint'(s));
        chk(out_burst == 2'b01, "R2", "burst", longint'(out_burst), 1);
        chk(out_pieces == 5'(n), "R3", "pieces", longint'(out_pieces), longint'(n));
        chk(out_last_piece == (got == n - 1), "R3", "last flag",
            longint'(out_last_piece), longint'(got == n - 1));
        chk(!out_lock, "R5", "lock", longint'(out_lock), 0);
        chk(out_qos == q, "R6", "qos", longint'(out_qos), longint'(q));
        chk(out_region == 4'h0, "R7", "region", longint'(out_region), 0);
        got++;
      end else if (out_valid) begin
        chk(out_addr == base + 32'(got << s), "R9", "stalled addr",
            longint'(out_addr), longint'(base + 32'(got << s)));
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid, "R8", "drained", longint'(out_valid), 0);
    chk(in_ready, "R8", "ready after drain", longint'(in_ready), 1);
  endtask

  initial begin
    logic [2:0] s;
    logic [7:0] l;
    logic [1:0] b;
    logic [31:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R10", "out_valid in reset", longint'(out_valid), 0);
    chk(!err_valid, "R10", "err_valid in reset", longint'(err_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !err_valid, "R10", "outputs after reset",
        longint'({out_valid, err_valid}), 0);
    chk(in_ready, "R10", "in_ready after reset", longint'(in_ready), 1);

    run_req(4'h1, 32'h0000_1003, 8'd5,  3'd0, 2'b01, 1'b0, 4'h3, 4'h0); // R1
    run_req(4'h2, 32'h0000_0100, 8'd3,  3'd2, 2'b10, 1'b0, 4'h5, 4'h0); // R2
    run_req(4'h3, 32'h0000_010C, 8'd3,  3'd2, 2'b10, 1'b0, 4'h7, 4'h0); // R3
    run_req(4'h4, 32'h0000_0003, 8'd15, 3'd0, 2'b10, 1'b1, 4'h9, 4'hA); // R3 R5 R7
    run_req(4'h5, 32'h0000_0048, 8'd7,  3'd3, 2'b10, 1'b0, 4'h0, 4'h0); // R3
    run_req(4'h6, 32'h0000_0200, 8'd4,  3'd1, 2'b00, 1'b0, 4'h1, 4'h0); // R4 fixed
    run_req(4'h7, 32'h0000_0200, 8'd1,  3'd1, 2'b11, 1'b0, 4'h1, 4'h0); // R4 reserved
    run_req(4'h8, 32'h0000_0204, 8'd2,  3'd1, 2'b10, 1'b0, 4'h1, 4'h0); // R4 bad wrap len
    run_req(4'h9, 32'h0000_0300, 8'd0,  3'd0, 2'b00, 1'b0, 4'h2, 4'h0); // R4
    run_req(4'hA, 32'h0000_0301, 8'd0,  3'd0, 2'b01, 1'b1, 4'hF, 4'h5); // R1 R5 R6 R7

    for (int i = 0; i < 400; i++) begin
      s = 3'($urandom % 4);
      case ($urandom % 4)
        0: l = 8'd1;
        1: l = 8'd3;
        2: l = 8'd7;
        default: l = 8'd15;
      endcase
      case ($urandom % 8)
        0: b = 2'b00;
        1: b = 2'b11;
        2, 3: b = 2'b01;
        default: b = 2'b10;
      endcase
      if (b == 2'b01) l = 8'($urandom);
      if (($urandom % 10) == 0 && b == 2'b10) l = 8'($urandom % 16);
      a = $urandom & ~((32'd1 << s) - 32'd1);
      run_req(4'($urandom), a, l, s, b, 1'($urandom), 4'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule